// File: doc/BRIEF.md
# Low-Power Mode and Wake-up Controller

This block sequences a processor core between three power states: Run, Idle and Sleep. A one-cycle sleep strobe from the instruction decoder requests a low-power state. The `deep_sel` bit chooses the state. Idle halts the core and keeps the oscillator running. Sleep also stops the oscillator. Leaving Sleep passes through a warm-up phase whose length is programmable, so the oscillator can settle before the core restarts.

The core leaves a low-power state in one of two ways:
- **Interrupt.** A masked peripheral request, a watchdog interrupt or the external interrupt ends the state. With `gie` low the core continues at the instruction after the sleep instruction. With `gie` high it takes the interrupt vector.
- **Sleep pin.** In Sleep only, the active-low sleep-control pin can also release the core. `slp_edge_mode` selects level or falling-edge sensitivity for this pin. The same bit also decides whether a Sleep request is allowed while the pin is high.

The external reset pin and a watchdog time-out return the block to Run from any state. All pins are plain control signals. No data moves through the block, so it has no valid/ready interface and applies no back-pressure. Everything runs on one free-running wake clock that stays alive while the main oscillator is stopped.

Top module: `lpm_wake_ctrl`

## Requirements
- R1: In Run, a `sleep_strobe` with `deep_sel`=0 moves to Idle on the next clock. In Idle, `cpu_halt`=1 and `osc_en`=1.
- R2: In Run, an accepted `sleep_strobe` with `deep_sel`=1 moves to Sleep on the next clock. In Sleep, `osc_en`=0 and `cpu_halt`=1.
- R3: Level mode (`slp_edge_mode`=0) has two rules:
  - A Sleep request is accepted only if the synchronised pin is low. Otherwise the block stays in Run and gives no pulse.
  - In Sleep, a synchronised high level on the pin releases the core.
- R4: Edge mode (`slp_edge_mode`=1) has three rules:
  - A Sleep request is accepted whatever the pin level.
  - In Sleep, a falling edge releases the core. The edge is found by comparing the synchronised sample with the one before it.
  - The pin has no effect in Idle.
- R5: A release from Sleep keeps `cpu_halt`=1 and `osc_en`=1 for L cycles. L is `warm_len`, or 16 when `warm_len` is 0, and `warm_cnt` shows the cycles left.
  - An interrupt applied before clock edge k gives its resume pulse after edge k+L. On the first warm-up cycle, `warm_cnt` reads L.
  - The pin passes two synchroniser flops, so a pin release gives its pulse after edge k+2+L.
- R6: In Idle or Sleep, any bit of `periph_irq`, `wdt_irq` or `ext_irq` wakes the core.
  - The resume is `resume_vector` if `gie` was 1 at the wake edge, and `resume_next` otherwise.
  - A pin release always gives `resume_next`.
  - From Idle, the pulse follows the request by one clock.
- R7: In Run, requests neither halt the core nor pulse a resume output, but each one sets its flag in `irq_pend`. The flag layout is: bits [NPERIPH-1:0] are peripherals, bit NPERIPH is the watchdog interrupt, and bit NPERIPH+1 is the external interrupt. A 1 in `pend_clr` clears the flag, and a new request wins over the clear.
- R8: Two conditions fully reset the block, and both override any request in the same cycle:
  - `ext_rst_n` low resets it asynchronously and holds `cpu_reset`=1.
  - A `wdt_timeout` sampled at a clock edge moves the block to Run, clears `irq_pend`, and drives `cpu_reset`=1 for the following cycle.
- R9: Each resume pulse lasts exactly one cycle. The two pulses are never high together, and a pulse appears only in the first Run cycle after a halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running wake clock |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_timeout | input | 1 | Watchdog time-out, causes a full reset |
| sleep_strobe | input | 1 | One-cycle sleep instruction strobe |
| deep_sel | input | 1 | 1 = Sleep, 0 = Idle |
| slp_edge_mode | input | 1 | Sleep-pin sensitivity: 0 level, 1 falling edge |
| slp_pin_n | input | 1 | Asynchronous sleep-control pin |
| periph_irq | input | NPERIPH | Masked peripheral interrupt requests |
| wdt_irq | input | 1 | Watchdog interrupt request |
| ext_irq | input | 1 | External interrupt request |
| gie | input | 1 | Global interrupt enable |
| warm_len | input | WARM_W | Warm-up length, 0 selects 16 |
| pend_clr | input | NPERIPH+2 | Clear mask for pending flags |
| osc_en | output | 1 | Main oscillator enable |
| cpu_halt | output | 1 | Core halt |
| warm_cnt | output | WARM_W | Remaining warm-up cycles |
| resume_next | output | 1 | Pulse: continue at the next instruction |
| resume_vector | output | 1 | Pulse: take the interrupt vector |
| cpu_reset | output | 1 | Full reset to the core |
| irq_pend | output | NPERIPH+2 | Recorded interrupt request flags |

## Verification
The table-driven part enters Idle and Sleep under each wake source: a peripheral bit, the watchdog interrupt, the external interrupt, a pin level and a pin edge. It also varies `gie` and the warm-up length. Measuring the latency of each pulse separates the Idle path from the Sleep path and the two-flop pin path from the direct interrupt path. The kind of pulse shows whether `gie` was honoured. Rows that must not halt or wake cover three cases:
- a level-mode Sleep request with the pin high,
- requests in Run,
- a pin edge in Idle.

Directed cases cover the visible warm-up count, pending-flag recording and clearing, a watchdog time-out that collides with a request, and an asynchronous reset from Idle.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_SLEEP = 2'd2,
    PM_WARM  = 2'd3
  } pm_state_e;
endpackage

// File: rtl/lpm_pin_sync.sv
module lpm_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic lvl,
  output logic fall
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], pin_n};
      prev_q <= sh_q[LAST];
    end
  end

  assign lvl  = sh_q[LAST];
  assign fall = prev_q & ~sh_q[LAST];
endmodule

// File: rtl/lpm_warmup.sv
module lpm_warmup #(
  parameter int W       = 8,
  parameter int DEFAULT = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic [W-1:0] cnt,
  output logic         last
);
  localparam logic [W-1:0] DEF_V = W'(DEFAULT);
  localparam logic [W-1:0] ONE   = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] eff_len;

  assign eff_len = (len == '0) ? DEF_V : len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr)            cnt_q <= '0;
    else if (load)           cnt_q <= eff_len;
    else if (cnt_q != '0)    cnt_q <= cnt_q - ONE;
  end

  assign cnt  = cnt_q;
  assign last = (cnt_q == ONE);
endmodule

// File: rtl/lpm_pend.sv
module lpm_pend #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_all,
  input  logic [N-1:0] req,
  input  logic [N-1:0] ack,
  output logic [N-1:0] pend
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       f_q <= 1'b0;
      else if (clr_all) f_q <= 1'b0;
      else if (req[g])  f_q <= 1'b1;
      else if (ack[g])  f_q <= 1'b0;
    end
    assign pend[g] = f_q;
  end
endmodule

// File: rtl/lpm_wake_ctrl.sv
module lpm_wake_ctrl #(
  parameter int NPERIPH      = 8,
  parameter int WARM_W       = 8,
  parameter int WARM_DEFAULT = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                 clk,
  input  logic                 ext_rst_n,
  input  logic                 wdt_timeout,
  input  logic                 sleep_strobe,
  input  logic                 deep_sel,
  input  logic                 slp_edge_mode,
  input  logic                 slp_pin_n,
  input  logic [NPERIPH-1:0]   periph_irq,
  input  logic                 wdt_irq,
  input  logic                 ext_irq,
  input  logic                 gie,
  input  logic [WARM_W-1:0]    warm_len,
  input  logic [NPERIPH+1:0]   pend_clr,
  output logic                 osc_en,
  output logic                 cpu_halt,
  output logic [WARM_W-1:0]    warm_cnt,
  output logic                 resume_next,
  output logic                 resume_vector,
  output logic                 cpu_reset,
  output logic [NPERIPH+1:0]   irq_pend
);
  import lpm_pkg::*;

  localparam int NSRC = NPERIPH + 2;

  pm_state_e state_q, state_d;
  logic      pin_lvl, pin_fall, pin_wake;
  logic      irq_any, sleep_ok;
  logic      warm_load, warm_last;
  logic      fire_next, fire_vec;
  logic      vec_q, vec_d;
  logic      res_next_q, res_vec_q, wdt_rst_q;
  logic [NSRC-1:0] req_vec;

  lpm_pin_sync #(.STAGES(SYNC_STAGES)) u_pin (
    .clk   (clk),
    .rst_n (ext_rst_n),
    .pin_n (slp_pin_n),
    .lvl   (pin_lvl),
    .fall  (pin_fall)
  );

  lpm_warmup #(.W(WARM_W), .DEFAULT(WARM_DEFAULT)) u_warm (
    .clk   (clk),
    .rst_n (ext_rst_n),
    .clr   (wdt_timeout),
    .load  (warm_load),
    .len   (warm_len),
    .cnt   (warm_cnt),
    .last  (warm_last)
  );

  assign req_vec = {ext_irq, wdt_irq, periph_irq};

  lpm_pend #(.N(NSRC)) u_pend (
    .clk     (clk),
    .rst_n   (ext_rst_n),
    .clr_all (wdt_timeout),
    .req     (req_vec),
    .ack     (pend_clr),
    .pend    (irq_pend)
  );

  assign irq_any  = |req_vec;
  assign sleep_ok = slp_edge_mode | ~pin_lvl;
  assign pin_wake = slp_edge_mode ? pin_fall : pin_lvl;

  always_comb begin
    state_d   = state_q;
    warm_load = 1'b0;
    vec_d     = vec_q;
    fire_next = 1'b0;
    fire_vec  = 1'b0;
    unique case (state_q)
      PM_RUN: begin
        if (sleep_strobe) begin
          if (!deep_sel)     state_d = PM_IDLE;
          else if (sleep_ok) state_d = PM_SLEEP;
        end
      end
      PM_IDLE: begin
        if (irq_any) begin
          state_d   = PM_RUN;
          fire_vec  = gie;
          fire_next = ~gie;
        end
      end
      PM_SLEEP: begin
        if (irq_any) begin
          state_d   = PM_WARM;
          warm_load = 1'b1;
          vec_d     = gie;
        end else if (pin_wake) begin
          state_d   = PM_WARM;
          warm_load = 1'b1;
          vec_d     = 1'b0;
        end
      end
      PM_WARM: begin
        if (warm_last) begin
          state_d   = PM_RUN;
          fire_vec  = vec_q;
          fire_next = ~vec_q;
        end
      end
      default: state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n) begin
      state_q    <= PM_RUN;
      vec_q      <= 1'b0;
      res_next_q <= 1'b0;
      res_vec_q  <= 1'b0;
      wdt_rst_q  <= 1'b0;
    end else begin
      wdt_rst_q <= wdt_timeout;
      if (wdt_timeout) begin
        state_q    <= PM_RUN;
        vec_q      <= 1'b0;
        res_next_q <= 1'b0;
        res_vec_q  <= 1'b0;
      end else begin
        state_q    <= state_d;
        vec_q      <= vec_d;
        res_next_q <= fire_next;
        res_vec_q  <= fire_vec;
      end
    end
  end

  assign osc_en        = (state_q != PM_SLEEP);
  assign cpu_halt      = (state_q != PM_RUN);
  assign resume_next   = res_next_q;
  assign resume_vector = res_vec_q;
  assign cpu_reset     = ~ext_rst_n | wdt_rst_q;
endmodule

// File: rtl/lpm_wake_ctrl_chk.sv
module lpm_wake_ctrl_chk #(
  parameter int WARM_W = 8,
  parameter int NSRC   = 10
) (
  input logic              clk,
  input logic              ext_rst_n,
  input logic              wdt_timeout,
  input logic              sleep_strobe,
  input logic              deep_sel,
  input logic              osc_en,
  input logic              cpu_halt,
  input logic [WARM_W-1:0] warm_cnt,
  input logic              resume_next,
  input logic              resume_vector,
  input logic [NSRC-1:0]   irq_pend
);
  a_r1_idle_entry: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (!cpu_halt && sleep_strobe && !deep_sel && !wdt_timeout) |=> (cpu_halt && osc_en));

  a_r2_osc_off_halted: assert property (@(posedge clk) disable iff (!ext_rst_n)
    !osc_en |-> (cpu_halt && !resume_next && !resume_vector));

  a_r5_warm_halts: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (warm_cnt != '0) |-> (cpu_halt && osc_en));

  a_r8_wdt_full_reset: assert property (@(posedge clk) disable iff (!ext_rst_n)
    wdt_timeout |=> (!cpu_halt && osc_en && irq_pend == '0));

  a_r9_next_single: assert property (@(posedge clk) disable iff (!ext_rst_n)
    resume_next |=> !resume_next);

  a_r9_vec_single: assert property (@(posedge clk) disable iff (!ext_rst_n)
    resume_vector |=> !resume_vector);

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!ext_rst_n)
    !(resume_next && resume_vector));

  a_r9_after_halt: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (resume_next || resume_vector) |-> (!cpu_halt && $past(cpu_halt)));
endmodule

bind lpm_wake_ctrl lpm_wake_ctrl_chk #(.WARM_W(WARM_W), .NSRC(NSRC)) i_chk (
  .clk           (clk),
  .ext_rst_n     (ext_rst_n),
  .wdt_timeout   (wdt_timeout),
  .sleep_strobe  (sleep_strobe),
  .deep_sel      (deep_sel),
  .osc_en        (osc_en),
  .cpu_halt      (cpu_halt),
  .warm_cnt      (warm_cnt),
  .resume_next   (resume_next),
  .resume_vector (resume_vector),
  .irq_pend      (irq_pend)
);

// File: tb/test_lpm_wake_ctrl.sv
`timescale 1ns/1ps
module test_lpm_wake_ctrl;
  localparam int NP = 8;
  localparam int NS = NP + 2;
  localparam int WW = 8;

  logic clk = 1'b0;
  logic ext_rst_n = 1'b0;
  logic wdt_timeout = 1'b0, sleep_strobe = 1'b0, deep_sel = 1'b0;
  logic slp_edge_mode = 1'b0, slp_pin_n = 1'b1;
  logic [NP-1:0] periph_irq = '0;
  logic wdt_irq = 1'b0, ext_irq = 1'b0, gie = 1'b0;
  logic [WW-1:0] warm_len = '0;
  logic [NS-1:0] pend_clr = '0;
  logic osc_en, cpu_halt, resume_next, resume_vector, cpu_reset;
  logic [WW-1:0] warm_cnt;
  logic [NS-1:0] irq_pend;

  always #2.5 clk = ~clk;

  lpm_wake_ctrl #(.NPERIPH(NP), .WARM_W(WW)) i_lpm_wake_ctrl (
    .clk(clk), .ext_rst_n(ext_rst_n), .wdt_timeout(wdt_timeout),
    .sleep_strobe(sleep_strobe), .deep_sel(deep_sel),
    .slp_edge_mode(slp_edge_mode), .slp_pin_n(slp_pin_n),
    .periph_irq(periph_irq), .wdt_irq(wdt_irq), .ext_irq(ext_irq),
    .gie(gie), .warm_len(warm_len), .pend_clr(pend_clr),
    .osc_en(osc_en), .cpu_halt(cpu_halt), .warm_cnt(warm_cnt),
    .resume_next(resume_next), .resume_vector(resume_vector),
    .cpu_reset(cpu_reset), .irq_pend(irq_pend));

  int n_cmp = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // src: 0 pin, 1 peripheral, 2 watchdog irq, 3 external irq
  // kind: 0 none, 1 resume_next, 2 resume_vector
  typedef struct packed {
    logic       edge_m;
    logic       deep;
    logic       pin0;
    logic       gie_v;
    logic [1:0] src;
    logic [7:0] warm;
    logic       halt;
    logic [1:0] kind;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 8'd0, 1'b1, 2'd1},  // R1 R6 idle periph
    '{1'b0, 1'b0, 1'b1, 1'b1, 2'd2, 8'd0, 1'b1, 2'd2},  // R6 idle wdt irq vector
    '{1'b1, 1'b0, 1'b1, 1'b0, 2'd3, 8'd0, 1'b1, 2'd1},  // R6 idle ext
    '{1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 8'd4, 1'b1, 2'd1},  // R3 level pin release
    '{1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 8'd5, 1'b1, 2'd2},  // R2 R5 sleep irq vector
    '{1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 8'd0, 1'b1, 2'd1},  // R4 R5 edge pin, default 16
    '{1'b1, 1'b1, 1'b1, 1'b0, 2'd3, 8'd3, 1'b1, 2'd1},  // R4 edge entry, ext wake
    '{1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 8'd0, 1'b0, 2'd0},  // R3 level refused, R7
    '{1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 8'd0, 1'b1, 2'd0}   // R4 pin ignored in idle
  };

  bit finished = 0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R8 reset state while pin held low
    check(cpu_reset == 1'b1, "R8 reset active", cpu_reset, 1);
    check(cpu_halt == 1'b0 && osc_en == 1'b1, "R8 reset state", {cpu_halt, osc_en}, 1);
    ext_rst_n = 1'b1;
    tick();
    check(cpu_reset == 1'b0 && irq_pend == '0, "R8 after release", cpu_reset, 0);
    check(resume_next == 1'b0 && resume_vector == 1'b0, "R9 idle pulses", resume_next, 0);

    for (int i = 0; i < 9; i++) begin
      vec_t v;
      int lat, kind, exp_lat, L;
      v = VEC[i];
      slp_edge_mode = v.edge_m; deep_sel = v.deep; slp_pin_n = v.pin0;
      gie = v.gie_v; warm_len = v.warm;
      pend_clr = '1;
      repeat (4) tick();
      pend_clr = '0;
      sleep_strobe = 1'b1;
      tick();
      sleep_strobe = 1'b0;
      check(cpu_halt == v.halt, $sformatf("R3 R4 row%0d halt", i), cpu_halt, v.halt);
      if (v.halt)
        check(osc_en == !v.deep, $sformatf("R1 R2 row%0d osc", i), osc_en, !v.deep);
      case (v.src)
        2'd0: slp_pin_n = v.edge_m ? 1'b0 : 1'b1;
        2'd1: periph_irq = 8'h04;
        2'd2: wdt_irq = 1'b1;
        default: ext_irq = 1'b1;
      endcase
      lat = 0; kind = 0;
      for (int c = 0; c < 40 && kind == 0; c++) begin
        tick();
        periph_irq = '0; wdt_irq = 1'b0; ext_irq = 1'b0;
        lat++;
        if (resume_next) kind = 1;
        else if (resume_vector) kind = 2;
      end
      L = (v.warm == 0) ? 16 : int'(v.warm);
      exp_lat = !v.deep ? 1 : ((v.src == 2'd0) ? 3 : 1) + L;
      check(kind == int'(v.kind), $sformatf("R6 row%0d kind", i), kind, v.kind);
      if (v.kind != 0)
        check(lat == exp_lat, $sformatf("R5 R6 row%0d latency", i), lat, exp_lat);
      if (kind == 0 && cpu_halt) begin
        periph_irq = 8'h01;
        tick();
        periph_irq = '0;
        tick();
        check(cpu_halt == 1'b0, $sformatf("R6 row%0d cleanup", i), cpu_halt, 0);
      end
    end

    // R5 visible warm count
    pend_clr = '1; slp_edge_mode = 1'b1; slp_pin_n = 1'b1; deep_sel = 1'b1;
    warm_len = 8'd6; gie = 1'b0;
    repeat (4) tick();
    pend_clr = '0;
    sleep_strobe = 1'b1; tick(); sleep_strobe = 1'b0;
    ext_irq = 1'b1; tick(); ext_irq = 1'b0;
    check(warm_cnt == 8'd6, "R5 warm count start", warm_cnt, 6);
    check(osc_en == 1'b1 && cpu_halt == 1'b1, "R5 warm halted", {osc_en, cpu_halt}, 3);
    repeat (8) tick();
    check(cpu_halt == 1'b0, "R5 warm done", cpu_halt, 0);

    // R7 request in Run: recorded, no effect
    pend_clr = '1; tick(); pend_clr = '0;
    ext_irq = 1'b1; tick(); ext_irq = 1'b0;
    check(cpu_halt == 1'b0 && resume_next == 1'b0 && resume_vector == 1'b0,
          "R7 run no effect", cpu_halt, 0);
    check(irq_pend == 10'h200, "R7 pend bit ext", irq_pend, 10'h200);
    pend_clr = 10'h200; tick(); pend_clr = '0;
    check(irq_pend == '0, "R7 pend clear", irq_pend, 0);

    // R8 watchdog time-out from Sleep, colliding with a request
    sleep_strobe = 1'b1; tick(); sleep_strobe = 1'b0;
    check(osc_en == 1'b0, "R2 sleep osc off", osc_en, 0);
    wdt_timeout = 1'b1; wdt_irq = 1'b1; tick(); wdt_timeout = 1'b0; wdt_irq = 1'b0;
    check(cpu_halt == 1'b0 && osc_en == 1'b1, "R8 wdt to run", {cpu_halt, osc_en}, 1);
    check(cpu_reset == 1'b1, "R8 wdt reset out", cpu_reset, 1);
    check(irq_pend == '0, "R8 wdt pend clear", irq_pend, 0);
    check(resume_next == 1'b0 && resume_vector == 1'b0, "R9 no pulse on reset", resume_next, 0);
    tick();
    check(cpu_reset == 1'b0, "R8 wdt reset one cycle", cpu_reset, 0);

    // R8 reset pin from Idle
    deep_sel = 1'b0;
    sleep_strobe = 1'b1; tick(); sleep_strobe = 1'b0;
    check(cpu_halt == 1'b1, "R1 idle entry", cpu_halt, 1);
    #1 ext_rst_n = 1'b0;
    #0.5;
    check(cpu_halt == 1'b0 && cpu_reset == 1'b1, "R8 pin reset async", cpu_halt, 0);
    tick();
    ext_rst_n = 1'b1;
    tick();
    check(cpu_reset == 1'b0 && cpu_halt == 1'b0, "R8 pin release", cpu_reset, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule